// File: doc/BRIEF.md
# Memory Pattern Synchronizer

This block brings a stored, user-defined repeating bit pattern into step with a serial received bit stream, so that later logic can compare each received bit with the bit the pattern says should arrive. The pattern occupies one to `DEPTH` words of `WORD_W` bits (128-bit words and 256 words by default). The repeat length in words is given at every start. Received bits arrive one per clock when `rx_valid` is high.

Two lock methods are offered. In scan mode the pattern has been written beforehand through a word write port. The block slides its alignment one bit phase at a time until a run of `MATCH_RUN` received bits agrees with the store. In capture mode nothing is preloaded. The block records one repeat length of line bits into the store, then requires the next two repeats to agree with that copy bit for bit. A mismatch sends it back to capture, up to a retry limit. Once locked, `exp_bit` gives, in the same cycle, the expected value of the bit currently presented on `rx_bit`.

States: IDLE (after reset), CAPTURE, VERIFY1, VERIFY2, SCAN, LOCKED, FAILED. Transitions:
- any state to FAILED on a start with a bad length;
- any state to CAPTURE (capture mode) or to SCAN (scan mode) on a start with a good length;
- CAPTURE to VERIFY1 on the last bit of a repeat;
- VERIFY1 to VERIFY2, and VERIFY2 to LOCKED, on the last matching bit of a repeat;
- VERIFY1 or VERIFY2 to CAPTURE on a mismatch while retries remain, and to FAILED when none remain;
- SCAN to LOCKED when the match run completes.

Top module: `mem_pattern_sync`

## Requirements
- R1: After reset, `locked`, `failed` and `len_err` are 0 and the block waits in IDLE.
- R2: A `start` with `len_words` equal to 0 or greater than `DEPTH` moves to FAILED one cycle later, with `failed`=1, `len_err`=1 and `locked`=0. A start with a legal length clears `len_err`.
- R3: In capture mode, the first L = `len_words`*`WORD_W` valid bits after start are written to the store in arrival order as pattern bits 0 to L-1.
- R4: After capture, two further passes of L valid bits are compared with the stored copy. `locked` rises in the cycle after the last bit of the second pass, and only if all 2L bits matched.
- R5: A mismatch in either verify pass drops that bit and restarts capture with the next valid bit. Before restarting, the block checks how many verify failures it has already retried since the start. If that count already equals `retry_limit`, it enters FAILED instead, with `failed`=1 and `len_err`=0.
- R6: Pattern bit i lives in word i/`WORD_W` at bit position i mod `WORD_W`, with bit 0 received first. In scan mode the alignment index starts at 0 and, for each valid bit, behaves as follows:
  - a match advances the index by one;
  - a mismatch advances the index by two, which shifts the trial bit phase by one, and restarts the match run;
  - the `MATCH_RUN`-th consecutive match enters LOCKED.
- R7: While locked, `exp_bit` equals stored pattern bit k, where k is the index aligned to the bit on `rx_bit`. The index advances by one per valid bit, modulo L. In capture mode k is 0 on the first bit after lock.
- R8: Cycles with `rx_valid`=0 (and no start) change neither the state nor the alignment index, so `locked` and `exp_bit` hold.
- R9: A `start` in any state abandons the current search or lock and begins a new one. With a legal length, `locked` and `failed` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new lock attempt (one-cycle pulse) |
| capture_mode | input | 1 | 1: capture then verify twice; 0: phase scan of preloaded store |
| len_words | input | $clog2(DEPTH+1) | Pattern repeat length in words, sampled at start |
| retry_limit | input | RETRY_W | Number of capture retries allowed after verify mismatches |
| pat_we | input | 1 | Word write strobe for preloading the store |
| pat_addr | input | $clog2(DEPTH) | Word address for preload |
| pat_wdata | input | WORD_W | Word data for preload |
| rx_valid | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received bit |
| exp_bit | output | 1 | Expected value of the current received bit while locked |
| locked | output | 1 | Pattern lock achieved |
| failed | output | 1 | Attempt abandoned (bad length or retries exhausted) |
| len_err | output | 1 | Last start carried an illegal length |

## Verification
Capture mode is driven first with a clean repeating 16-bit pattern. This shows that lock needs exactly three repeats: lock is absent one bit before the end and present one bit after. It is then driven with a single flipped bit in a verify pass. With a retry limit of zero this must end in FAILED, and with a limit of two it must re-capture and still lock, which separates the retry path from the abort path. Scan mode is driven with an aperiodic 24-bit pattern spread over three words and started at a non-zero offset. The only lock it can reach is the true alignment, so a correct `exp_bit` stream afterwards confirms both the bit-phase stepping and the word/bit layout. Gaps in `rx_valid`, a restart while locked, and both illegal lengths each test one hold or abort path against the cycle-by-cycle reference model.

// File: rtl/msync_pkg.sv
`timescale 1ns/1ps
package msync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_VERIFY1 = 3'd2,
        ST_VERIFY2 = 3'd3,
        ST_SCAN    = 3'd4,
        ST_LOCKED  = 3'd5,
        ST_FAILED  = 3'd6
    } msync_state_t;

endpackage

// File: rtl/msync_pattern_ram.sv
`timescale 1ns/1ps
// Pattern store: word-wide preload port, single-bit write and read by bit index.
module msync_pattern_ram #(
    parameter int WORD_W = 128,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int SH    = $clog2(WORD_W),
    localparam int IDX_W = AW + SH
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              bit_we,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              bit_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);

    logic [WORD_W-1:0] rows [DEPTH];

    logic [AW-1:0] wr_word;
    logic [SH-1:0] wr_pos;
    logic [AW-1:0] rd_word;
    logic [SH-1:0] rd_pos;

    assign wr_word = bit_idx[IDX_W-1:SH];
    assign wr_pos  = bit_idx[SH-1:0];
    assign rd_word = rd_idx[IDX_W-1:SH];
    assign rd_pos  = rd_idx[SH-1:0];

    // Line capture takes precedence over a host word write.
    always_ff @(posedge clk) begin
        if (bit_we) begin
            rows[wr_word][wr_pos] <= bit_val;
        end else if (host_we) begin
            rows[host_addr] <= host_wdata;
        end
    end

    assign rd_bit = rows[rd_word][rd_pos];

endmodule

// File: rtl/msync_bit_ptr.sv
`timescale 1ns/1ps
// Cyclic bit index over 0..last_idx, advancing by one or two.
module msync_bit_ptr #(
    parameter int IDX_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step1,
    input  logic             step2,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);

    logic [IDX_W:0] raw_sum;
    logic [IDX_W:0] wrapped;
    logic [IDX_W:0] last_ext;

    assign last_ext = {1'b0, last_idx};

    always_comb begin
        raw_sum = {1'b0, idx} + (step2 ? (IDX_W+1)'(2) : (IDX_W+1)'(1));
        if (raw_sum > last_ext) begin
            wrapped = raw_sum - last_ext - (IDX_W+1)'(1);
        end else begin
            wrapped = raw_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (step1 || step2) begin
            idx <= wrapped[IDX_W-1:0];
        end
    end

    assign at_last = (idx == last_idx);

endmodule

// File: rtl/msync_run_ctr.sv
`timescale 1ns/1ps
// Consecutive-match counter for the phase scan.
module msync_run_ctr #(
    parameter int MATCH_RUN = 256,
    localparam int RUN_W    = $clog2(MATCH_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic final_match
);

    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr) begin
            run_cnt <= '0;
        end else if (inc) begin
            run_cnt <= run_cnt + RUN_W'(1);
        end
    end

    // True when the next match completes the run.
    assign final_match = (run_cnt == RUN_W'(MATCH_RUN - 1));

endmodule

// File: rtl/msync_ctrl.sv
`timescale 1ns/1ps
// Lock state machine for both synchronisation methods.
module msync_ctrl
    import msync_pkg::*;
#(
    parameter int WORD_W  = 128,
    parameter int DEPTH   = 256,
    parameter int RETRY_W = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int SH     = $clog2(WORD_W),
    localparam int IDX_W  = AW + SH,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               capture_mode,
    input  logic [LW-1:0]      len_words,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               rx_valid,
    input  logic               rx_bit,
    input  logic               ref_bit,
    input  logic               at_last,
    input  logic               final_match,
    output logic               ptr_clr,
    output logic               step1,
    output logic               step2,
    output logic               bit_we,
    output logic               run_clr,
    output logic               run_inc,
    output logic [IDX_W-1:0]   last_idx,
    output logic               locked,
    output logic               failed,
    output logic               len_err
);

    msync_state_t state_q, state_d;

    logic [RETRY_W-1:0] retry_q;
    logic               retry_inc;
    logic               retry_clr;
    logic               load_len;
    logic               set_len_err;
    logic               len_bad;
    logic               bit_match;
    logic               retry_spent;
    logic [IDX_W:0]     len_ext;
    logic [IDX_W:0]     last_calc;
    logic [IDX_W-1:0]   last_q;
    logic               len_err_q;

    assign len_bad     = (len_words == '0) || (len_words > LW'(DEPTH));
    assign bit_match   = (rx_bit == ref_bit);
    assign retry_spent = (retry_q == retry_limit);
    assign len_ext     = (IDX_W+1)'(len_words);
    assign last_calc   = (len_ext << SH) - (IDX_W+1)'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Attempt bookkeeping: length, retries, length error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q    <= '0;
            retry_q   <= '0;
            len_err_q <= 1'b0;
        end else begin
            if (load_len) begin
                last_q    <= last_calc[IDX_W-1:0];
                len_err_q <= set_len_err;
            end
            if (retry_clr) begin
                retry_q <= '0;
            end else if (retry_inc) begin
                retry_q <= retry_q + RETRY_W'(1);
            end
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_d     = state_q;
        ptr_clr     = 1'b0;
        step1       = 1'b0;
        step2       = 1'b0;
        bit_we      = 1'b0;
        run_clr     = 1'b0;
        run_inc     = 1'b0;
        retry_inc   = 1'b0;
        retry_clr   = 1'b0;
        load_len    = 1'b0;
        set_len_err = 1'b0;

        if (start) begin
            load_len  = 1'b1;
            ptr_clr   = 1'b1;
            run_clr   = 1'b1;
            retry_clr = 1'b1;
            if (len_bad) begin
                set_len_err = 1'b1;
                state_d     = ST_FAILED;
            end else if (capture_mode) begin
                state_d = ST_CAPTURE;
            end else begin
                state_d = ST_SCAN;
            end
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FAILED: begin
                end
                ST_CAPTURE: begin
                    if (rx_valid) begin
                        bit_we = 1'b1;
                        if (at_last) begin
                            ptr_clr = 1'b1;
                            state_d = ST_VERIFY1;
                        end else begin
                            step1 = 1'b1;
                        end
                    end
                end
                ST_VERIFY1, ST_VERIFY2: begin
                    if (rx_valid) begin
                        if (!bit_match) begin
                            ptr_clr = 1'b1;
                            if (retry_spent) begin
                                state_d = ST_FAILED;
                            end else begin
                                retry_inc = 1'b1;
                                state_d   = ST_CAPTURE;
                            end
                        end else if (at_last) begin
                            ptr_clr = 1'b1;
                            state_d = (state_q == ST_VERIFY1) ? ST_VERIFY2 : ST_LOCKED;
                        end else begin
                            step1 = 1'b1;
                        end
                    end
                end
                ST_SCAN: begin
                    if (rx_valid) begin
                        if (bit_match) begin
                            step1 = 1'b1;
                            if (final_match) begin
                                run_clr = 1'b1;
                                state_d = ST_LOCKED;
                            end else begin
                                run_inc = 1'b1;
                            end
                        end else begin
                            step2   = 1'b1;
                            run_clr = 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (rx_valid) begin
                        step1 = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        locked   = (state_q == ST_LOCKED);
        failed   = (state_q == ST_FAILED);
        len_err  = len_err_q;
        last_idx = last_q;
    end

endmodule

// File: rtl/mem_pattern_sync.sv
`timescale 1ns/1ps
// Memory pattern synchronizer top level.
module mem_pattern_sync #(
    parameter int WORD_W    = 128,
    parameter int DEPTH     = 256,
    parameter int MATCH_RUN = 256,
    parameter int RETRY_W   = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int SH       = $clog2(WORD_W),
    localparam int IDX_W    = AW + SH,
    localparam int LW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               capture_mode,
    input  logic [LW-1:0]      len_words,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               pat_we,
    input  logic [AW-1:0]      pat_addr,
    input  logic [WORD_W-1:0]  pat_wdata,
    input  logic               rx_valid,
    input  logic               rx_bit,
    output logic               exp_bit,
    output logic               locked,
    output logic               failed,
    output logic               len_err
);

    logic             ptr_clr;
    logic             step1;
    logic             step2;
    logic             bit_we;
    logic             run_clr;
    logic             run_inc;
    logic             final_match;
    logic             at_last;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] bit_idx;
    logic             ref_bit;

    msync_ctrl #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .RETRY_W(RETRY_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .capture_mode(capture_mode),
        .len_words   (len_words),
        .retry_limit (retry_limit),
        .rx_valid    (rx_valid),
        .rx_bit      (rx_bit),
        .ref_bit     (ref_bit),
        .at_last     (at_last),
        .final_match (final_match),
        .ptr_clr     (ptr_clr),
        .step1       (step1),
        .step2       (step2),
        .bit_we      (bit_we),
        .run_clr     (run_clr),
        .run_inc     (run_inc),
        .last_idx    (last_idx),
        .locked      (locked),
        .failed      (failed),
        .len_err     (len_err)
    );

    msync_bit_ptr #(
        .IDX_W(IDX_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ptr_clr),
        .step1   (step1),
        .step2   (step2),
        .last_idx(last_idx),
        .idx     (bit_idx),
        .at_last (at_last)
    );

    msync_run_ctr #(
        .MATCH_RUN(MATCH_RUN)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (run_clr),
        .inc        (run_inc),
        .final_match(final_match)
    );

    msync_pattern_ram #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk       (clk),
        .host_we   (pat_we),
        .host_addr (pat_addr),
        .host_wdata(pat_wdata),
        .bit_we    (bit_we),
        .bit_idx   (bit_idx),
        .bit_val   (rx_bit),
        .rd_idx    (bit_idx),
        .rd_bit    (ref_bit)
    );

    assign exp_bit = ref_bit;

endmodule

// File: rtl/msync_checks.sv
`timescale 1ns/1ps
// Port-level properties of the synchronizer.
module msync_checks #(
    parameter int DEPTH = 256,
    parameter int LW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [LW-1:0] len_words,
    input logic          rx_valid,
    input logic          pat_we,
    input logic          exp_bit,
    input logic          locked,
    input logic          failed,
    input logic          len_err
);

    logic bad_len;
    assign bad_len = (len_words == '0) || (len_words > LW'(DEPTH));

    p_bad_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && bad_len |=> failed && len_err && !locked);

    p_len_err_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> failed);

    p_lock_fail_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && failed));

    p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        failed && !start |=> failed);

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !rx_valid && !start |=> locked);

    p_exp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !rx_valid && !start && !pat_we |=> $stable(exp_bit));

    p_lock_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && !start |=> !locked || $past(rx_valid));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !bad_len |=> !locked && !failed && !len_err);

endmodule

bind mem_pattern_sync msync_checks #(
    .DEPTH(DEPTH),
    .LW   (LW)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_words(len_words),
    .rx_valid (rx_valid),
    .pat_we   (pat_we),
    .exp_bit  (exp_bit),
    .locked   (locked),
    .failed   (failed),
    .len_err  (len_err)
);

// File: tb/mem_pattern_sync_tb.sv
`timescale 1ns/1ps
module mem_pattern_sync_tb;

    localparam int W   = 8;
    localparam int D   = 4;
    localparam int MR  = 24;
    localparam int RW  = 3;
    localparam int AW  = $clog2(D);
    localparam int LW  = $clog2(D + 1);
    localparam int NB  = W * D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          capture_mode = 1'b0;
    logic [LW-1:0] len_words = '0;
    logic [RW-1:0] retry_limit = '0;
    logic          pat_we = 1'b0;
    logic [AW-1:0] pat_addr = '0;
    logic [W-1:0]  pat_wdata = '0;
    logic          rx_valid = 1'b0;
    logic          rx_bit = 1'b0;
    logic          exp_bit;
    logic          locked;
    logic          failed;
    logic          len_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mem_pattern_sync #(
        .WORD_W(W), .DEPTH(D), .MATCH_RUN(MR), .RETRY_W(RW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .capture_mode(capture_mode),
        .len_words(len_words), .retry_limit(retry_limit), .pat_we(pat_we),
        .pat_addr(pat_addr), .pat_wdata(pat_wdata), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .exp_bit(exp_bit), .locked(locked), .failed(failed),
        .len_err(len_err)
    );

    task automatic check_eq(input int act, input int expv, input string tag);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 capture, 2 verify1, 3 verify2, 4 scan, 5 locked, 6 failed
    int m_state;
    int m_idx;
    int m_len;
    int m_run;
    int m_retry;
    bit m_lenerr;
    bit m_pat [NB];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_len = 1; m_run = 0; m_retry = 0; m_lenerr = 0;
        end else begin
            if (pat_we) begin
                for (int b = 0; b < W; b++) m_pat[int'(pat_addr) * W + b] = pat_wdata[b];
            end
            if (start) begin
                m_idx = 0; m_run = 0; m_retry = 0;
                if (len_words == 0 || int'(len_words) > D) begin
                    m_state = 6; m_lenerr = 1;
                end else begin
                    m_lenerr = 0; m_len = int'(len_words) * W;
                    m_state = capture_mode ? 1 : 4;
                end
            end else if (rx_valid) begin
                case (m_state)
                    1: begin
                        m_pat[m_idx] = rx_bit;
                        if (m_idx == m_len - 1) begin m_idx = 0; m_state = 2; end
                        else m_idx++;
                    end
                    2, 3: begin
                        if (rx_bit != m_pat[m_idx]) begin
                            m_idx = 0;
                            if (m_retry == int'(retry_limit)) m_state = 6;
                            else begin m_retry++; m_state = 1; end
                        end else if (m_idx == m_len - 1) begin
                            m_idx = 0; m_state = (m_state == 2) ? 3 : 5;
                        end else m_idx++;
                    end
                    4: begin
                        if (rx_bit == m_pat[m_idx]) begin
                            m_idx = (m_idx + 1) % m_len;
                            m_run++;
                            if (m_run == MR) begin m_run = 0; m_state = 5; end
                        end else begin
                            m_idx = (m_idx + 2) % m_len;
                            m_run = 0;
                        end
                    end
                    5: m_idx = (m_idx + 1) % m_len;
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check_eq(int'(locked), int'(m_state == 5), "R4 R6 locked vs model");
            check_eq(int'(failed), int'(m_state == 6), "R2 R5 failed vs model");
            check_eq(int'(len_err), int'(m_lenerr), "R2 len_err vs model");
            if (m_state == 5) check_eq(int'(exp_bit), int'(m_pat[m_idx]), "R7 exp_bit vs model");
        end
    end

    task automatic cyc(input bit v, input bit b);
        @(negedge clk);
        start = 0; pat_we = 0; rx_valid = v; rx_bit = b;
    endtask

    task automatic do_start(input bit md, input int len, input int rl);
        @(negedge clk);
        start = 1; capture_mode = md; len_words = LW'(len); retry_limit = RW'(rl);
        pat_we = 0; rx_valid = 0;
    endtask

    task automatic send_bits(input logic [15:0] p, input int nbits, input int flip);
        for (int i = 0; i < nbits; i++) cyc(1'b1, p[i] ^ (i == flip));
    endtask

    localparam logic [15:0] PAT16 = 16'hB38E;
    localparam logic [23:0] PAT24 = 24'h800003;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc(0, 0);
        // R1: reset state
        check_eq(int'(locked), 0, "R1 locked after reset");
        check_eq(int'(failed), 0, "R1 failed after reset");
        check_eq(int'(len_err), 0, "R1 len_err after reset");

        // R2: illegal lengths
        do_start(1, 0, 0); cyc(0, 0);
        check_eq(int'(failed), 1, "R2 len 0 failed");
        check_eq(int'(len_err), 1, "R2 len 0 len_err");
        do_start(0, 5, 0); cyc(0, 0);
        check_eq(int'(len_err), 1, "R2 len 5 len_err");
        check_eq(int'(locked), 0, "R2 len 5 not locked");

        // R3 R4: clean capture of a 2-word pattern
        do_start(1, 2, 0); cyc(0, 0);
        check_eq(int'(len_err), 0, "R2 legal start clears len_err");
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 15, -1);
        cyc(0, 0);
        check_eq(int'(locked), 0, "R4 not locked before last verify bit");
        cyc(1, PAT16[15]);
        cyc(0, 0);
        check_eq(int'(locked), 1, "R4 locked after two verify passes");
        // R3 R7: expected stream from phase 0 of captured copy
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 16; i++) begin
                cyc(1, PAT16[i]);
                check_eq(int'(exp_bit), int'(PAT16[i]), "R3 R7 exp_bit after capture lock");
            end
        end

        // R8: gaps hold lock and expected bit
        begin
            logic held;
            cyc(0, 0);
            held = exp_bit;
            repeat (3) cyc(0, 0);
            check_eq(int'(locked), 1, "R8 lock held over gap");
            check_eq(int'(exp_bit), int'(held), "R8 exp_bit held over gap");
        end

        // R9: restart while locked
        do_start(1, 2, 0); cyc(0, 0);
        check_eq(int'(locked), 0, "R9 restart drops lock");
        check_eq(int'(failed), 0, "R9 restart not failed");

        // R5: no retries allowed, mismatch in verify
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 16, 3);
        cyc(0, 0);
        check_eq(int'(failed), 1, "R5 retries exhausted");
        check_eq(int'(len_err), 0, "R5 len_err stays low");

        // R5: two retries allowed, two mismatches then lock
        do_start(1, 2, 2);
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 6, 5);
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 10, 9);
        cyc(0, 0);
        check_eq(int'(failed), 0, "R5 retry still in progress");
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 16, -1);
        send_bits(PAT16, 16, -1);
        cyc(0, 0);
        check_eq(int'(locked), 1, "R5 lock after retries");

        // R6: preload 3 words, scan from an offset stream
        do_start(1, 0, 0);
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            start = 0; rx_valid = 0; pat_we = 1;
            pat_addr = AW'(w); pat_wdata = PAT24[w*W +: W];
        end
        do_start(0, 3, 0);
        for (int t = 0; t < 800; t++) cyc(1, PAT24[(t + 5) % 24]);
        cyc(0, 0);
        check_eq(int'(locked), 1, "R6 scan lock reached");
        for (int t = 800; t < 848; t++) begin
            cyc(1, PAT24[(t + 5) % 24]);
            check_eq(int'(exp_bit), int'(PAT24[(t + 5) % 24]), "R6 R7 exp_bit after scan lock");
        end
        cyc(0, 0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule